// File: doc/BRIEF.md
# Predicated ALU with Condition Flags

This block is the integer execute unit of a 32-bit load/store processor. In any cycle where `issue_valid` is high it takes one operation: the second operand first passes through a shifter, then the arithmetic or logic stage combines it with the first operand. The block keeps the four status flags (negative, zero, carry, overflow) in its own register. Every operation carries a 4-bit condition selector that is tested against the flags held at issue. If the condition fails, the operation leaves no trace: no result is written and the flags do not change.

All outputs are registered. The result and its write strobe appear one clock after the issue edge, and the new flags are visible from that same edge. Operations arrive one per cycle with no back-pressure, because the unit accepts every cycle and has no internal occupancy. There is therefore no ready signal, and a caller may issue back to back. Compare and test operations exist only to set flags, so they never raise the write strobe. Reserved opcode, shift and condition codes have defined, harmless behaviour.

Top module: `alu_flags_unit`

## Requirements
- R1: After reset `result` is 0, `result_we` is 0 and `flags` (bit order N,Z,C,V from bit 3 down to bit 0) is 4'b0000.
- R2: ADD (opcode 0) of 0xFFFFFFFF and 1 gives result 0 with flags 4'b0110. ADD of 0x7FFFFFFF and 1 gives 0x80000000 with flags 4'b1001.
- R3: ADC (opcode 1) adds the held C as carry-in. SBC (opcode 3) computes a - b - (1 - C).
- R4: SUB (opcode 2) sets C to 1 exactly when no borrow occurs (a >= b unsigned). V is set on signed overflow of a - b.
- R5: The logic opcodes are AND=4, ORR=5, EOR=6, BIC=7 (a AND NOT b), MOV=8 (b) and MVN=9 (NOT b). They set N and Z from the result, take C from the shifter carry-out and keep V.
- R6: Shift kind codes for operand b are LSL=0, LSR=1, ASR=2 and ROR=3, by `shift_amt` from 1 to 31. The shifter carry-out is the last bit shifted out (for ROR, the new bit 31).
- R7: A shift amount of 0 with kinds 0 to 3 passes b unchanged and the shifter carry-out equals the held C. Shift codes 5 to 7 behave the same way.
- R8: Shift kind RRX=4 ignores the amount. It produces {C, b[31:1]} with carry-out b[0].
- R9: CMP=10 (as SUB), CMN=11 (as ADD), TST=12 (as AND) and TEQ=13 (as EOR) update the flags even when `set_flags` is 0, and never assert `result_we`.
- R10: The condition codes are EQ=0 Z, NE=1 !Z, CS=2 C, CC=3 !C, MI=4 N, PL=5 !N, VS=6 V, VC=7 !V, HI=8 C&!Z, LS=9 !C|Z, GE=10 N==V, LT=11 N!=V, GT=12 !Z&(N==V), LE=13 Z|(N!=V) and AL=14 (always). Code 15 never passes.
- R11: When the condition fails, `result_we` stays 0, `result` holds its previous value and `flags` do not change.
- R12: A passing opcode 0 to 9 with `set_flags` 0 writes its result and leaves the flags unchanged. Opcodes 14 and 15 write nothing and change nothing.
- R13: With `issue_valid` low, `result_we` is 0 and `result` and `flags` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | An operation is presented this cycle |
| opcode | input | 4 | Operation code |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand, before shifting |
| shift_kind | input | 3 | Shift applied to op_b |
| shift_amt | input | 5 | Shift distance |
| set_flags | input | 1 | Request flag update for opcodes 0 to 9 |
| cond | input | 4 | Condition selector |
| result | output | 32 | Last written result |
| result_we | output | 1 | One-cycle strobe: result was written |
| flags | output | 4 | Held N,Z,C,V |

## Verification
The bench sweeps every opcode over operand pairs drawn from the signed and unsigned extremes. These pairs provoke carry with and without overflow, borrow on equal and unequal values, and zero results. A unit that took C straight from the adder on subtraction, or that cleared V on logic operations, would show wrong flags on these pairs. Every shift kind is also driven at every amount from 0 to 31, so an off-by-one in the carry bit index, or a zero-amount shift that emits a carry, shows up at once. Each of the sixteen condition codes is then tested against flag states reached through real compares. This catches swapped polarities such as HI versus LS, as well as a failed condition that still updates the flags.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBC = 4'd3,
    OP_AND = 4'd4,  OP_ORR = 4'd5,  OP_EOR = 4'd6,  OP_BIC = 4'd7,
    OP_MOV = 4'd8,  OP_MVN = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_TST = 4'd12, OP_TEQ = 4'd13, OP_RS14 = 4'd14, OP_RS15 = 4'd15
  } alu_op_e;

  typedef enum logic [2:0] {
    SH_LSL = 3'd0, SH_LSR = 3'd1, SH_ASR = 3'd2, SH_ROR = 3'd3,
    SH_RRX = 3'd4, SH_RS5 = 3'd5, SH_RS6 = 3'd6, SH_RS7 = 3'd7
  } shift_e;

  typedef enum logic [3:0] {
    CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_CS = 4'd2,  CC_CC = 4'd3,
    CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
    CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
    CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_NV = 4'd15
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

endpackage

// File: rtl/alu_shifter.sv
module alu_shifter
  import alu_flags_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int AW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] operand,
  input  logic [2:0]       kind,
  input  logic [AW-1:0]    amount,
  input  logic             carry_in,
  output logic [WIDTH-1:0] shifted,
  output logic             carry_out
);

  logic [AW-1:0] left_idx;
  logic [AW-1:0] right_idx;

  always_comb begin
    left_idx  = AW'(WIDTH - int'(amount));
    right_idx = AW'(int'(amount) - 1);
    shifted   = operand;
    carry_out = carry_in;
    case (shift_e'(kind))
      SH_LSL: if (amount != '0) begin
        shifted   = operand << amount;
        carry_out = operand[left_idx];
      end
      SH_LSR: if (amount != '0) begin
        shifted   = operand >> amount;
        carry_out = operand[right_idx];
      end
      SH_ASR: if (amount != '0) begin
        shifted   = $signed(operand) >>> amount;
        carry_out = operand[right_idx];
      end
      SH_ROR: if (amount != '0) begin
        shifted   = (operand >> amount) | (operand << (WIDTH - int'(amount)));
        carry_out = operand[right_idx];
      end
      SH_RRX: begin
        shifted   = {carry_in, operand[WIDTH-1:1]};
        carry_out = operand[0];
      end
      default: begin
        shifted   = operand;
        carry_out = carry_in;
      end
    endcase
  end

  always_comb begin
    if (kind == 3'(SH_RRX))
      a_r8_rrx_carry: assert (carry_out == operand[0]);
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_flags_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sh_carry,
  input  logic             c_in,
  input  logic             v_in,
  output logic [WIDTH-1:0] res,
  output nzcv_t            flags_out,
  output logic             writes,
  output logic             forced_flags,
  output logic             legal
);

  logic [WIDTH-1:0] b_eff;
  logic             cin;
  logic [WIDTH:0]   sum;
  logic             is_arith;
  logic             ovf;
  logic [WIDTH-1:0] logic_res;

  always_comb begin
    b_eff    = b;
    cin      = 1'b0;
    is_arith = 1'b0;
    case (alu_op_e'(op))
      OP_ADD, OP_CMN: is_arith = 1'b1;
      OP_ADC:         begin is_arith = 1'b1; cin = c_in; end
      OP_SUB, OP_CMP: begin is_arith = 1'b1; b_eff = ~b; cin = 1'b1; end
      OP_SBC:         begin is_arith = 1'b1; b_eff = ~b; cin = c_in; end
      default:        is_arith = 1'b0;
    endcase
    sum = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin};
    ovf = (a[WIDTH-1] == b_eff[WIDTH-1]) && (sum[WIDTH-1] != a[WIDTH-1]);
  end

  always_comb begin
    case (alu_op_e'(op))
      OP_AND, OP_TST: logic_res = a & b;
      OP_ORR:         logic_res = a | b;
      OP_EOR, OP_TEQ: logic_res = a ^ b;
      OP_BIC:         logic_res = a & ~b;
      OP_MOV:         logic_res = b;
      OP_MVN:         logic_res = ~b;
      default:        logic_res = '0;
    endcase
  end

  always_comb begin
    res          = is_arith ? sum[WIDTH-1:0] : logic_res;
    flags_out.n  = res[WIDTH-1];
    flags_out.z  = (res == '0);
    flags_out.c  = is_arith ? sum[WIDTH] : sh_carry;
    flags_out.v  = is_arith ? ovf : v_in;
    writes       = (op <= 4'(OP_MVN));
    forced_flags = (op >= 4'(OP_CMP)) && (op <= 4'(OP_TEQ));
    legal        = (op <= 4'(OP_TEQ));
  end

  always_comb begin
    if ((op == 4'(OP_SUB) || op == 4'(OP_CMP)) && a == b)
      a_r4_equal_no_borrow: assert (flags_out.z && flags_out.c);
  end

endmodule

// File: rtl/alu_cond.sv
module alu_cond
  import alu_flags_pkg::*;
(
  input  logic [3:0] cond,
  input  nzcv_t      f,
  output logic       pass
);

  always_comb begin
    case (cond_e'(cond))
      CC_EQ:   pass = f.z;
      CC_NE:   pass = !f.z;
      CC_CS:   pass = f.c;
      CC_CC:   pass = !f.c;
      CC_MI:   pass = f.n;
      CC_PL:   pass = !f.n;
      CC_VS:   pass = f.v;
      CC_VC:   pass = !f.v;
      CC_HI:   pass = f.c && !f.z;
      CC_LS:   pass = !f.c || f.z;
      CC_GE:   pass = (f.n == f.v);
      CC_LT:   pass = (f.n != f.v);
      CC_GT:   pass = !f.z && (f.n == f.v);
      CC_LE:   pass = f.z || (f.n != f.v);
      CC_AL:   pass = 1'b1;
      default: pass = 1'b0;
    endcase
  end

  always_comb begin
    if (cond == 4'(CC_AL))
      a_r10_always_passes: assert (pass);
    if (cond == 4'(CC_NV))
      a_r10_never_passes: assert (!pass);
  end

endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
  import alu_flags_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int AW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_valid,
  input  logic [3:0]       opcode,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [2:0]       shift_kind,
  input  logic [AW-1:0]    shift_amt,
  input  logic             set_flags,
  input  logic [3:0]       cond,
  output logic [WIDTH-1:0] result,
  output logic             result_we,
  output logic [3:0]       flags
);

  nzcv_t            flag_q;
  nzcv_t            flag_next;
  logic [WIDTH-1:0] b_shifted;
  logic             sh_carry;
  logic [WIDTH-1:0] core_res;
  logic             core_writes;
  logic             core_forced;
  logic             core_legal;
  logic             cond_ok;
  logic             do_write;
  logic             do_flags;

  alu_shifter #(.WIDTH(WIDTH)) u_shifter (
    .operand   (op_b),
    .kind      (shift_kind),
    .amount    (shift_amt),
    .carry_in  (flag_q.c),
    .shifted   (b_shifted),
    .carry_out (sh_carry)
  );

  alu_core #(.WIDTH(WIDTH)) u_core (
    .op           (opcode),
    .a            (op_a),
    .b            (b_shifted),
    .sh_carry     (sh_carry),
    .c_in         (flag_q.c),
    .v_in         (flag_q.v),
    .res          (core_res),
    .flags_out    (flag_next),
    .writes       (core_writes),
    .forced_flags (core_forced),
    .legal        (core_legal)
  );

  alu_cond u_cond (
    .cond (cond),
    .f    (flag_q),
    .pass (cond_ok)
  );

  assign do_write = issue_valid && cond_ok && core_writes;
  assign do_flags = issue_valid && cond_ok && core_legal && (set_flags || core_forced);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result    <= '0;
      result_we <= 1'b0;
      flag_q    <= '0;
    end else begin
      result_we <= do_write;
      if (do_write) result <= core_res;
      if (do_flags) flag_q <= flag_next;
    end
  end

  assign flags = flag_q;

  a_r9_compare_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && opcode >= 4'(OP_CMP) && opcode <= 4'(OP_TEQ)) |=> !result_we);

  a_r11_fail_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !cond_ok) |=> (!result_we && $stable(flags) && $stable(result)));

  a_r12_no_setflags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !set_flags && opcode <= 4'(OP_MVN)) |=> $stable(flags));

  a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |=> (!result_we && $stable(flags) && $stable(result)));

endmodule

// File: tb/alu_flags_unit_bench.sv
module alu_flags_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0;
  logic [3:0]  opcode = '0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [2:0]  shift_kind = '0;
  logic [4:0]  shift_amt = '0;
  logic        set_flags = 1'b0;
  logic [3:0]  cond = 4'd14;
  logic [31:0] result;
  logic        result_we;
  logic [3:0]  flags;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_res = '0;
  logic [3:0]  mf = '0;
  logic [31:0] vals [8];

  always #5 clk = ~clk;

  alu_flags_unit u_alu_flags_unit (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .opcode(opcode),
    .op_a(op_a), .op_b(op_b), .shift_kind(shift_kind), .shift_amt(shift_amt),
    .set_flags(set_flags), .cond(cond), .result(result), .result_we(result_we),
    .flags(flags)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model(input [3:0] op, input [31:0] a, input [31:0] b, input [2:0] sk,
                       input [4:0] sa, input sf, input [3:0] cc, input [3:0] fin,
                       output [31:0] r, output we, output [3:0] fout, output upd, output pass);
    logic n, z, c, v, bc, carry, ovf, br;
    logic [31:0] bsh;
    logic [63:0] t;
    logic signed [63:0] ts, sx;
    n = fin[3]; z = fin[2]; c = fin[1]; v = fin[0];
    bsh = b; bc = c;
    case (sk)
      3'd0: begin t = {32'b0, b} << sa; if (sa != 0) begin bsh = t[31:0]; bc = t[32]; end end
      3'd1: begin t = {b, 32'b0} >> sa; if (sa != 0) begin bsh = t[63:32]; bc = t[31]; end end
      3'd2: begin ts = {b, 32'b0}; ts = ts >>> sa; if (sa != 0) begin bsh = ts[63:32]; bc = ts[31]; end end
      3'd3: begin t = {b, b} >> sa; if (sa != 0) begin bsh = t[31:0]; bc = t[31]; end end
      3'd4: begin bsh = {c, b[31:1]}; bc = b[0]; end
      default: ;
    endcase
    case (cc)
      4'd0: pass = z;          4'd1: pass = !z;
      4'd2: pass = c;          4'd3: pass = !c;
      4'd4: pass = n;          4'd5: pass = !n;
      4'd6: pass = v;          4'd7: pass = !v;
      4'd8: pass = c && !z;    4'd9: pass = !c || z;
      4'd10: pass = n == v;    4'd11: pass = n != v;
      4'd12: pass = !z && n == v;
      4'd13: pass = z || n != v;
      4'd14: pass = 1'b1;
      default: pass = 1'b0;
    endcase
    carry = bc; ovf = v; r = 32'h0;
    case (op)
      4'd0, 4'd1, 4'd11: begin
        br = (op == 4'd1) ? c : 1'b0;
        t = {32'b0, a} + {32'b0, bsh} + {63'b0, br};
        sx = $signed({{32{a[31]}}, a}) + $signed({{32{bsh[31]}}, bsh}) + $signed({63'b0, br});
        carry = t[32];
        ovf = (sx > 64'sd2147483647) || (sx < -64'sd2147483648);
        r = sx[31:0];
      end
      4'd2, 4'd3, 4'd10: begin
        br = (op == 4'd3) ? !c : 1'b0;
        sx = $signed({{32{a[31]}}, a}) - $signed({{32{bsh[31]}}, bsh}) - $signed({63'b0, br});
        carry = {32'b0, a} >= ({32'b0, bsh} + {63'b0, br});
        ovf = (sx > 64'sd2147483647) || (sx < -64'sd2147483648);
        r = sx[31:0];
      end
      4'd4, 4'd12: r = a & bsh;
      4'd5: r = a | bsh;
      4'd6, 4'd13: r = a ^ bsh;
      4'd7: r = a & ~bsh;
      4'd8: r = bsh;
      4'd9: r = ~bsh;
      default: r = 32'h0;
    endcase
    fout = {r[31], r == 32'h0, carry, ovf};
    we = pass && (op <= 4'd9);
    upd = pass && (op <= 4'd13) && (sf || op >= 4'd10);
  endtask

  task automatic issue(input string tag, input [3:0] op, input [31:0] a, input [31:0] b,
                       input [2:0] sk, input [4:0] sa, input sf, input [3:0] cc);
    logic [31:0] r; logic we, upd, pass; logic [3:0] fo;
    string t;
    @(negedge clk);
    issue_valid = 1'b1; opcode = op; op_a = a; op_b = b;
    shift_kind = sk; shift_amt = sa; set_flags = sf; cond = cc;
    model(op, a, b, sk, sa, sf, cc, mf, r, we, fo, upd, pass);
    t = !pass ? "R11" : (op >= 4'd10 && op <= 4'd13) ? "R9" : tag;
    if (we) exp_res = r;
    if (upd) mf = fo;
    @(posedge clk); #1;
    chk(t, "result", result, exp_res);
    chk(t, "result_we", {31'b0, result_we}, {31'b0, we});
    chk(t, "flags", {28'b0, flags}, {28'b0, mf});
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    vals[0] = 32'h0;        vals[1] = 32'h1;        vals[2] = 32'h2;
    vals[3] = 32'h7fffffff; vals[4] = 32'h80000000; vals[5] = 32'hffffffff;
    vals[6] = 32'h12345678; vals[7] = 32'hf0f0000f;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    chk("R1", "result", result, 32'h0);
    chk("R1", "result_we", {31'b0, result_we}, 32'h0);
    chk("R1", "flags", {28'b0, flags}, 32'h0);

    // R2 the two stated addition examples
    issue("R2", 4'd0, 32'hffffffff, 32'h1, 3'd0, 5'd0, 1'b1, 4'd14);
    chk("R2", "literal result", result, 32'h0);
    chk("R2", "literal flags", {28'b0, flags}, 32'h6);
    issue("R2", 4'd0, 32'h7fffffff, 32'h1, 3'd0, 5'd0, 1'b1, 4'd14);
    chk("R2", "literal result", result, 32'h80000000);
    chk("R2", "literal flags", {28'b0, flags}, 32'h9);

    // R3 carry-in use, with C first set then cleared
    issue("R4", 4'd2, 32'd5, 32'd3, 3'd0, 5'd0, 1'b1, 4'd14);
    issue("R3", 4'd1, 32'd1, 32'd1, 3'd0, 5'd0, 1'b0, 4'd14);
    issue("R3", 4'd3, 32'd5, 32'd3, 3'd0, 5'd0, 1'b0, 4'd14);
    issue("R4", 4'd2, 32'd3, 32'd5, 3'd0, 5'd0, 1'b1, 4'd14);
    issue("R3", 4'd3, 32'd5, 32'd3, 3'd0, 5'd0, 1'b0, 4'd14);
    chk("R3", "literal sbc", result, 32'd1);
    issue("R3", 4'd1, 32'd1, 32'd1, 3'd0, 5'd0, 1'b1, 4'd14);
    chk("R3", "literal adc", result, 32'd2);

    // R12 no flag request, and reserved opcodes
    issue("R12", 4'd0, 32'hffffffff, 32'h1, 3'd0, 5'd0, 1'b0, 4'd14);
    issue("R12", 4'd14, 32'h5, 32'h5, 3'd0, 5'd0, 1'b1, 4'd14);
    issue("R12", 4'd15, 32'h0, 32'h0, 3'd0, 5'd0, 1'b1, 4'd14);

    // R13 idle cycles with changing inputs
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      issue_valid = 1'b0; opcode = 4'd8; op_b = 32'hdead0000 + k; set_flags = 1'b1; cond = 4'd14;
      @(posedge clk); #1;
      chk("R13", "result_we", {31'b0, result_we}, 32'h0);
      chk("R13", "result", result, exp_res);
      chk("R13", "flags", {28'b0, flags}, {28'b0, mf});
    end

    // R4 R5 all opcodes over operand pairs, varied shifts
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          issue((op <= 3) ? "R4" : "R5", 4'(op), vals[i], vals[j],
                3'((i + j + op) % 6), 5'((i * 7 + j * 3) % 32), 1'b1, 4'd14);

    // R6 R7 R8 shift sweep through MOV
    for (int k = 0; k < 8; k++)
      for (int a = 0; a < 32; a++)
        for (int v = 3; v < 8; v += 2)
          issue((k == 4) ? "R8" : (k > 4 || a == 0) ? "R7" : "R6",
                4'd8, 32'h0, vals[v], 3'(k), 5'(a), 1'b1, 4'd14);

    // R10 R11 condition sweep over flag states reached by compares
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        issue("R9", 4'(10 + ((i + j) % 4)), vals[i], vals[j], 3'd0, 5'd0, 1'b0, 4'd14);
        for (int cc = 0; cc < 16; cc++)
          issue("R10", 4'd9, 32'h0, 32'(cc * 17 + i), 3'd0, 5'd0, 1'b0, 4'(cc));
        issue("R11", 4'd0, vals[j], vals[i], 3'd0, 5'd0, 1'b1, 4'(i + 8));
      end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule